// File: doc/BRIEF.md
# Field-Selected Nibble Arithmetic Unit

This unit performs digit arithmetic, logic and comparison on wide registers made of 4-bit digits. Only a window of digits, bounded by a low and a high digit index, takes part in an operation. Every digit outside that window passes through unchanged. A mode input chooses plain hexadecimal digits or decimal (BCD) digits with decimal carry and borrow correction. The results are a destination register, a second destination used only by exchange, and one carry/test flag.

The datapath processes one digit per clock. A small controller has three states:

- IDLE waits for an execute strobe.
- CALC walks upward from the low index for the arithmetic and logic group, carrying the running carry from digit to digit.
- SCAN walks downward from the high index for the compare group. It stops at the first digit that differs.

Transitions:

- IDLE→CALC on a strobe with a valid window and an op code below 16.
- IDLE→SCAN on a strobe with a valid window and an op code of 16 or above.
- IDLE→IDLE on a strobe whose low index exceeds the high index. This is the empty window: done is given and nothing changes.
- CALC→IDLE after the high digit is processed.
- SCAN→IDLE once the result is decided.

Operands are captured on the accepting clock edge. The done pulse marks the cycle in which the outputs are final.

Top module: `nib_field_alu`

## Requirements
- R1: After any accepted operation with lo_i <= hi_i, digits of res_o outside [lo_i, hi_i] equal those of a_i, and digits of res_b_o outside the window equal those of b_i.
- R2: Op codes ADD (0) and SUB (1) with dec_mode_i=0 start with carry 0. Each digit result is taken modulo 16, and the carry into the next digit is set by a sum above 15 or by a negative difference. carry_o is the carry out of the high digit.
- R3: With dec_mode_i=1, a digit sum of 10 or more yields the sum minus 10 with a carry. A negative digit difference yields the difference plus 10 with a borrow.
- R4: INC (2) and DEC (3) act on a_i alone, starting with an incoming carry of 1, in either mode. carry_o is the final carry or borrow.
- R5: NEG (4) computes zero minus the window of a_i in the selected radix. carry_o is 1 exactly when any result digit in the window is nonzero.
- R6: NOT (5) maps each window digit d to 15-d in hex mode and to 9-d in decimal mode, and clears carry_o.
- R7: AND (6), OR (7), CLR (8), COPY (9, window of b_i into res_o) and EXCHANGE (10, windows of a_i and b_i swapped between res_o and res_b_o) leave carry_o at its previous value.
- R8: ADDI (11) adds imm_i+1 into the low window digit. The carry ripples upward, the operation is always done in hex whatever dec_mode_i says, and carry_o is the final carry.
- R9: Tests return res_o=a_i and res_b_o=b_i. EQ (16) sets carry_o iff the windows match and NE (17) is its inverse. ZERO (18) sets carry_o iff the window of a_i is all zero, ignoring b_i, and NONZERO (19) is its inverse.
- R10: GT (20), GE (21), LT (22) and LE (23) compare the windows from the high digit down, and the first unequal digit decides. With equal windows GT and LT give 0, and GE and LE give 1.
- R11: done_o is a one-cycle pulse. For the CALC group it arrives n clocks after the accepting edge, where n = hi_i-lo_i+1. For the SCAN group it arrives after as many clocks as digits scanned, up to and including the deciding digit. busy_o is high in between, and carry_o changes only in a done cycle.
- R12: A strobe with lo_i > hi_i gives done_o one clock later and leaves res_o, res_b_o and carry_o unchanged.
- R13: A strobe while busy_o is high is ignored, including in the cycle of the final digit. A strobe in the done cycle starts a new operation.
- R14: After reset, res_o, res_b_o, carry_o, busy_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe, accepted only when idle |
| op_i | input | 5 | Operation code |
| dec_mode_i | input | 1 | 1 = decimal digits, 0 = hexadecimal |
| lo_i | input | 4 | Low digit index of the window |
| hi_i | input | 4 | High digit index of the window |
| imm_i | input | 4 | Immediate for ADDI (adds imm_i+1) |
| a_i | input | 64 | First operand and destination source |
| b_i | input | 64 | Second operand |
| res_o | output | 64 | Destination register |
| res_b_o | output | 64 | Second destination (exchange) |
| carry_o | output | 1 | Carry / test flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can share one cycle here. The first is a new execute strobe arriving while the final digit of a running operation is being written. The second is a strobe arriving in the done cycle itself. The bench holds the strobe high through every busy cycle, including the last one, while presenting different operands. It then judges that the result, the latency and the absence of a second done pulse all match the first operation alone. A separate case raises the strobe exactly in the done cycle and expects a clean second result after the first has been read.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_INC  = 5'd2,
        OP_DEC  = 5'd3,
        OP_NEG  = 5'd4,
        OP_NOT  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_CLR  = 5'd8,
        OP_CPY  = 5'd9,
        OP_XCH  = 5'd10,
        OP_ADDI = 5'd11,
        OP_EQ   = 5'd16,
        OP_NE   = 5'd17,
        OP_ZR   = 5'd18,
        OP_NZ   = 5'd19,
        OP_GT   = 5'd20,
        OP_GE   = 5'd21,
        OP_LT   = 5'd22,
        OP_LE   = 5'd23
    } nfa_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_SCAN = 2'd2
    } nfa_state_e;

    localparam int DEC_RADIX = 10;

endpackage

// File: rtl/nfa_nib_pick.sv
module nfa_nib_pick #(
    parameter int NIB_W = 4,
    parameter int NIBS  = 16,
    localparam int IDX_W = $clog2(NIBS)
) (
    input  logic [NIB_W*NIBS-1:0] vec_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic [NIB_W-1:0]      nib_o
);
    logic [NIB_W-1:0] lanes [NIBS];

    for (genvar g = 0; g < NIBS; g++) begin : g_lane
        assign lanes[g] = vec_i[g*NIB_W +: NIB_W];
    end

    assign nib_o = lanes[idx_i];
endmodule

// File: rtl/nfa_digit_alu.sv
module nfa_digit_alu
    import nfa_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int CW = NIB_W + 1,
    localparam int EW = NIB_W + 4
) (
    input  nfa_op_e          op_i,
    input  logic             dec_i,
    input  logic [NIB_W-1:0] da_i,
    input  logic [NIB_W-1:0] db_i,
    input  logic [CW-1:0]    cin_i,
    output logic [NIB_W-1:0] dout_o,
    output logic [CW-1:0]    cout_o
);
    localparam logic [NIB_W-1:0] HEX_MAX = '1;
    localparam logic [NIB_W-1:0] DEC_MAX = NIB_W'(DEC_RADIX - 1);

    logic          bcd;
    logic [EW-1:0] sum;
    logic [EW-1:0] diff;
    logic [NIB_W-1:0] addend, minu, subt;
    logic          neg;

    always_comb begin
        // immediate add ignores the radix mode (R8)
        bcd    = dec_i && (op_i != OP_ADDI);
        addend = (op_i == OP_ADD) ? db_i : '0;
        minu   = (op_i == OP_NEG) ? '0 : da_i;
        case (op_i)
            OP_SUB:  subt = db_i;
            OP_NEG:  subt = da_i;
            default: subt = '0;
        endcase
        sum  = EW'(da_i) + EW'(addend) + EW'(cin_i);
        diff = EW'(minu) - EW'(subt) - EW'(cin_i);
        neg  = diff[EW-1];

        dout_o = da_i;
        cout_o = '0;
        unique case (op_i)
            OP_ADD, OP_INC, OP_ADDI: begin
                if (bcd && (sum >= EW'(DEC_RADIX))) begin
                    dout_o = NIB_W'(sum - EW'(DEC_RADIX));
                    cout_o = CW'(1);
                end else if (bcd) begin
                    dout_o = NIB_W'(sum);
                end else begin
                    dout_o = sum[NIB_W-1:0];
                    cout_o = CW'(sum >> NIB_W);
                end
            end
            OP_SUB, OP_DEC, OP_NEG: begin
                if (bcd && neg) dout_o = diff[NIB_W-1:0] + NIB_W'(DEC_RADIX);
                else            dout_o = diff[NIB_W-1:0];
                cout_o = CW'(neg);
            end
            OP_NOT:  dout_o = bcd ? (DEC_MAX - da_i) : (HEX_MAX - da_i);
            OP_AND:  dout_o = da_i & db_i;
            OP_OR:   dout_o = da_i | db_i;
            OP_CLR:  dout_o = '0;
            OP_CPY, OP_XCH: dout_o = db_i;
            default: dout_o = da_i;
        endcase
    end
endmodule

// File: rtl/nfa_scan_judge.sv
module nfa_scan_judge
    import nfa_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  nfa_op_e          op_i,
    input  logic [NIB_W-1:0] da_i,
    input  logic [NIB_W-1:0] db_i,
    input  logic             at_low_i,
    output logic             stop_o,
    output logic             flag_o
);
    logic [NIB_W-1:0] ref_d;
    logic             differ;

    always_comb begin
        ref_d  = ((op_i == OP_ZR) || (op_i == OP_NZ)) ? '0 : db_i;
        differ = (da_i != ref_d);
        stop_o = differ || at_low_i;
        flag_o = 1'b0;
        if (differ) begin
            unique case (op_i)
                OP_NE, OP_NZ:  flag_o = 1'b1;
                OP_GT, OP_GE:  flag_o = (da_i > ref_d);
                OP_LT, OP_LE:  flag_o = (da_i < ref_d);
                default:       flag_o = 1'b0;
            endcase
        end else begin
            unique case (op_i)
                OP_EQ, OP_ZR, OP_GE, OP_LE: flag_o = 1'b1;
                default:                    flag_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/nib_field_alu.sv
module nib_field_alu
    import nfa_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int NIBS  = 16,
    localparam int REG_W = NIB_W * NIBS,
    localparam int IDX_W = $clog2(NIBS),
    localparam int CW    = NIB_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  logic [4:0]       op_i,
    input  logic             dec_mode_i,
    input  logic [IDX_W-1:0] lo_i,
    input  logic [IDX_W-1:0] hi_i,
    input  logic [NIB_W-1:0] imm_i,
    input  logic [REG_W-1:0] a_i,
    input  logic [REG_W-1:0] b_i,
    output logic [REG_W-1:0] res_o,
    output logic [REG_W-1:0] res_b_o,
    output logic             carry_o,
    output logic             busy_o,
    output logic             done_o
);
    nfa_state_e       state_q, state_d;
    nfa_op_e          op_q, op_in;
    logic             dec_q;
    logic [IDX_W-1:0] idx_q, lo_q, hi_q;
    logic [REG_W-1:0] acc_q, accb_q;
    logic [CW-1:0]    run_c_q, cin_init;
    logic             nz_q, carry_q, done_q;

    logic [NIB_W-1:0] da, db, dout;
    logic [CW-1:0]    cout;
    logic             stop, flag;
    logic             accept, accept_walk, accept_empty;
    logic             fin_calc, fin_scan;
    logic             calc_carry;

    assign op_in = nfa_op_e'(op_i);

    nfa_nib_pick #(.NIB_W(NIB_W), .NIBS(NIBS)) u_pick_a (
        .vec_i(acc_q), .idx_i(idx_q), .nib_o(da)
    );
    nfa_nib_pick #(.NIB_W(NIB_W), .NIBS(NIBS)) u_pick_b (
        .vec_i(accb_q), .idx_i(idx_q), .nib_o(db)
    );
    nfa_digit_alu #(.NIB_W(NIB_W)) u_digit (
        .op_i(op_q), .dec_i(dec_q), .da_i(da), .db_i(db),
        .cin_i(run_c_q), .dout_o(dout), .cout_o(cout)
    );
    nfa_scan_judge #(.NIB_W(NIB_W)) u_judge (
        .op_i(op_q), .da_i(da), .db_i(db), .at_low_i(idx_q == lo_q),
        .stop_o(stop), .flag_o(flag)
    );

    // control decode
    always_comb begin
        accept       = (state_q == ST_IDLE) && exec_i;
        accept_walk  = accept && (lo_i <= hi_i);
        accept_empty = accept && (lo_i > hi_i);
        fin_calc     = (state_q == ST_CALC) && (idx_q == hi_q);
        fin_scan     = (state_q == ST_SCAN) && stop;
        unique case (op_in)
            OP_ADDI:        cin_init = CW'(imm_i) + CW'(1);
            OP_INC, OP_DEC: cin_init = CW'(1);
            default:        cin_init = '0;
        endcase
        unique case (op_q)
            OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_ADDI: calc_carry = cout[0];
            OP_NEG:  calc_carry = nz_q || (dout != '0);
            OP_NOT:  calc_carry = 1'b0;
            default: calc_carry = carry_q;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept_walk) state_d = op_i[4] ? ST_SCAN : ST_CALC;
            ST_CALC: if (fin_calc)    state_d = ST_IDLE;
            ST_SCAN: if (fin_scan)    state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_ADD;
            dec_q   <= 1'b0;
            idx_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            acc_q   <= '0;
            accb_q  <= '0;
            run_c_q <= '0;
            nz_q    <= 1'b0;
            carry_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= accept_empty || fin_calc || fin_scan;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_walk) begin
                        op_q    <= op_in;
                        dec_q   <= dec_mode_i;
                        lo_q    <= lo_i;
                        hi_q    <= hi_i;
                        acc_q   <= a_i;
                        accb_q  <= b_i;
                        nz_q    <= 1'b0;
                        run_c_q <= cin_init;
                        idx_q   <= op_i[4] ? hi_i : lo_i;
                    end
                end
                ST_CALC: begin
                    // only the digit at idx_q is written (R1)
                    acc_q[idx_q*NIB_W +: NIB_W] <= dout;
                    if (op_q == OP_XCH) accb_q[idx_q*NIB_W +: NIB_W] <= da;
                    run_c_q <= cout;
                    nz_q    <= nz_q || (dout != '0);
                    if (fin_calc) carry_q <= calc_carry;
                    else          idx_q   <= idx_q + IDX_W'(1);
                end
                ST_SCAN: begin
                    if (fin_scan) carry_q <= flag;
                    else          idx_q   <= idx_q - IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign res_o   = acc_q;
    assign res_b_o = accb_q;
    assign carry_o = carry_q;
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
endmodule

// File: rtl/nfa_alu_checker.sv
module nfa_alu_checker #(
    parameter int NIB_W = 4,
    parameter int NIBS  = 16,
    localparam int REG_W = NIB_W * NIBS,
    localparam int IDX_W = $clog2(NIBS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_i,
    input logic [IDX_W-1:0] lo_i,
    input logic [IDX_W-1:0] hi_i,
    input logic [IDX_W-1:0] lo_q,
    input logic [IDX_W-1:0] hi_q,
    input logic [REG_W-1:0] res_o,
    input logic             carry_o,
    input logic             busy_o,
    input logic             done_o
);
    logic [REG_W-1:0] fmask;
    logic [7:0]       run_len;

    always_comb begin
        for (int i = 0; i < NIBS; i++)
            fmask[i*NIB_W +: NIB_W] =
                ((lo_q <= IDX_W'(i)) && (IDX_W'(i) <= hi_q)) ? '1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_len <= '0;
        else if (busy_o) run_len <= run_len + 8'd1;
        else             run_len <= '0;
    end

    assert_field_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o) |-> (((res_o ^ $past(res_o)) & ~fmask) == '0));

    assert_empty_field_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !busy_o && (lo_i > hi_i)) |=> (done_o && $stable(res_o) && $stable(carry_o)));

    assert_carry_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry_o) |-> done_o);

    assert_busy_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 8'(NIBS));

    assert_start_needs_exec_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(exec_i));
endmodule

bind nib_field_alu nfa_alu_checker #(.NIB_W(NIB_W), .NIBS(NIBS)) u_chk (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .lo_i(lo_i), .hi_i(hi_i),
    .lo_q(lo_q), .hi_q(hi_q), .res_o(res_o), .carry_o(carry_o),
    .busy_o(busy_o), .done_o(done_o)
);

// File: tb/nib_field_alu_bench.sv
`timescale 1ns/1ps
module nib_field_alu_bench;
    import nfa_pkg::*;

    typedef struct packed {
        nfa_op_e     op;
        logic        dec;
        logic [3:0]  lo;
        logic [3:0]  hi;
        logic [3:0]  imm;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] er;
        logic [63:0] eb;
        logic        ec;
        logic [4:0]  lat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        // R2 hex add, carry out of high digit
        '{OP_ADD, 1'b0, 4'd0, 4'd3, 4'd0, 64'h1111_2222_3333_F00F, 64'h9999_8888_7777_0FF1,
          64'h1111_2222_3333_0000, 64'h9999_8888_7777_0FF1, 1'b1, 5'd4, 4'd2},
        // R3 decimal add 0358+0647
        '{OP_ADD, 1'b1, 4'd4, 4'd7, 4'd0, 64'h0000_0000_0358_AAAA, 64'h0000_0000_0647_BBBB,
          64'h0000_0000_1005_AAAA, 64'h0000_0000_0647_BBBB, 1'b0, 5'd4, 4'd3},
        // R2 hex subtract with borrow
        '{OP_SUB, 1'b0, 4'd0, 4'd1, 4'd0, 64'hABCD_0000_0000_0010, 64'h0000_0000_0000_0020,
          64'hABCD_0000_0000_00F0, 64'h0000_0000_0000_0020, 1'b1, 5'd2, 4'd2},
        // R3 decimal subtract 100-1
        '{OP_SUB, 1'b1, 4'd0, 4'd2, 4'd0, 64'h5555_5555_5555_5100, 64'h0000_0000_0000_0001,
          64'h5555_5555_5555_5099, 64'h0000_0000_0000_0001, 1'b0, 5'd3, 4'd3},
        // R4 hex increment, full width
        '{OP_INC, 1'b0, 4'd0, 4'd15, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_1234,
          64'h0000_0000_0000_0000, 64'h0000_0000_0000_1234, 1'b1, 5'd16, 4'd4},
        // R4 decimal decrement 2000-1
        '{OP_DEC, 1'b1, 4'd8, 4'd11, 4'd0, 64'h7777_2000_7777_7777, 64'h0,
          64'h7777_1999_7777_7777, 64'h0, 1'b0, 5'd4, 4'd4},
        // R5 hex negate nonzero
        '{OP_NEG, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_0001, 64'h0,
          64'h0000_0000_0000_FFFF, 64'h0, 1'b1, 5'd4, 4'd5},
        // R5 decimal negate of zero window
        '{OP_NEG, 1'b1, 4'd0, 4'd2, 4'd0, 64'h1234_0000_0000_9000, 64'h0,
          64'h1234_0000_0000_9000, 64'h0, 1'b0, 5'd3, 4'd5},
        // R6 hex ones complement
        '{OP_NOT, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_1234, 64'h0,
          64'h0000_0000_0000_EDCB, 64'h0, 1'b0, 5'd4, 4'd6},
        // R6 decimal nines complement
        '{OP_NOT, 1'b1, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_1234, 64'h0,
          64'h0000_0000_0000_8765, 64'h0, 1'b0, 5'd4, 4'd6},
        // R8 immediate add forced hex although dec=1
        '{OP_ADDI, 1'b1, 4'd0, 4'd3, 4'd15, 64'h0000_0000_0000_00F5, 64'h0,
          64'h0000_0000_0000_0105, 64'h0, 1'b0, 5'd4, 4'd8},
        // R8 immediate add single digit, carry out
        '{OP_ADDI, 1'b0, 4'd0, 4'd0, 4'd0, 64'h8000_0000_0000_000F, 64'h0,
          64'h8000_0000_0000_0000, 64'h0, 1'b1, 5'd1, 4'd8},
        // R7 AND keeps carry
        '{OP_AND, 1'b0, 4'd4, 4'd7, 4'd0, 64'hFFFF_FFFF_F0F0_FFFF, 64'h0000_0000_3C3C_0000,
          64'hFFFF_FFFF_3030_FFFF, 64'h0000_0000_3C3C_0000, 1'b1, 5'd4, 4'd7},
        // R7 OR
        '{OP_OR, 1'b0, 4'd0, 4'd1, 4'd0, 64'h0000_0000_0000_0A05, 64'h0000_0000_0000_0050,
          64'h0000_0000_0000_0A55, 64'h0000_0000_0000_0050, 1'b1, 5'd2, 4'd7},
        // R1 clear of top digits, rest untouched
        '{OP_CLR, 1'b0, 4'd12, 4'd15, 4'd0, 64'hABCD_1234_5678_9ABC, 64'h0,
          64'h0000_1234_5678_9ABC, 64'h0, 1'b1, 5'd4, 4'd1},
        // R7 copy
        '{OP_CPY, 1'b0, 4'd0, 4'd3, 4'd0, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222,
          64'h1111_1111_1111_2222, 64'h2222_2222_2222_2222, 1'b1, 5'd4, 4'd7},
        // R7 exchange
        '{OP_XCH, 1'b0, 4'd4, 4'd5, 4'd0, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222,
          64'h1111_1111_1122_1111, 64'h2222_2222_2211_2222, 1'b1, 5'd2, 4'd7},
        // R9 equal, outside digits differ
        '{OP_EQ, 1'b0, 4'd0, 4'd3, 4'd0, 64'hAAAA_0000_0000_1234, 64'hBBBB_0000_0000_1234,
          64'hAAAA_0000_0000_1234, 64'hBBBB_0000_0000_1234, 1'b1, 5'd4, 4'd9},
        // R9 equal fails at low digit
        '{OP_EQ, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_1235,
          64'h0000_0000_0000_1234, 64'h0000_0000_0000_1235, 1'b0, 5'd4, 4'd9},
        // R9 not-equal decided at high digit
        '{OP_NE, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_9234,
          64'h0000_0000_0000_1234, 64'h0000_0000_0000_9234, 1'b1, 5'd1, 4'd9},
        // R9 zero test ignores b
        '{OP_ZR, 1'b0, 4'd0, 4'd3, 4'd0, 64'hFFFF_FFFF_FFFF_0000, 64'h0000_0000_0000_0001,
          64'hFFFF_FFFF_FFFF_0000, 64'h0000_0000_0000_0001, 1'b1, 5'd4, 4'd9},
        // R9 nonzero found at digit 5
        '{OP_NZ, 1'b0, 4'd4, 4'd7, 4'd0, 64'h0000_0000_0010_0000, 64'h0,
          64'h0000_0000_0010_0000, 64'h0, 1'b1, 5'd3, 4'd9},
        // R10 greater, decided at second digit
        '{OP_GT, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_1934, 64'h0000_0000_0000_1854,
          64'h0000_0000_0000_1934, 64'h0000_0000_0000_1854, 1'b1, 5'd2, 4'd10},
        // R10 greater on equal windows
        '{OP_GT, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_4444, 64'h0000_0000_0000_4444,
          64'h0000_0000_0000_4444, 64'h0000_0000_0000_4444, 1'b0, 5'd4, 4'd10},
        // R10 greater-or-equal on equal windows
        '{OP_GE, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_4444, 64'h0000_0000_0000_4444,
          64'h0000_0000_0000_4444, 64'h0000_0000_0000_4444, 1'b1, 5'd4, 4'd10},
        // R10 less, decided at third digit
        '{OP_LT, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_1243,
          64'h0000_0000_0000_1234, 64'h0000_0000_0000_1243, 1'b1, 5'd3, 4'd10},
        // R10 less-or-equal false at high digit
        '{OP_LE, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_5000, 64'h0000_0000_0000_4999,
          64'h0000_0000_0000_5000, 64'h0000_0000_0000_4999, 1'b0, 5'd1, 4'd10},
        // R10 less on equal windows
        '{OP_LT, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_4444, 64'h0000_0000_0000_4444,
          64'h0000_0000_0000_4444, 64'h0000_0000_0000_4444, 1'b0, 5'd4, 4'd10},
        // R10 less-or-equal on equal windows
        '{OP_LE, 1'b0, 4'd0, 4'd3, 4'd0, 64'h0000_0000_0000_4444, 64'h0000_0000_0000_4444,
          64'h0000_0000_0000_4444, 64'h0000_0000_0000_4444, 1'b1, 5'd4, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic        dec_mode_i = 1'b0;
    logic [3:0]  lo_i = '0, hi_i = '0, imm_i = '0;
    logic [63:0] a_i = '0, b_i = '0;
    logic [63:0] res_o, res_b_o;
    logic        carry_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nib_field_alu u_nib_field_alu (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
        .dec_mode_i(dec_mode_i), .lo_i(lo_i), .hi_i(hi_i), .imm_i(imm_i),
        .a_i(a_i), .b_i(b_i), .res_o(res_o), .res_b_o(res_b_o),
        .carry_o(carry_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_i = v.op; dec_mode_i = v.dec; lo_i = v.lo; hi_i = v.hi;
        imm_i = v.imm; a_i = v.a; b_i = v.b;
    endtask

    task automatic run_vec(input vec_t v);
        int lat;
        @(negedge clk);
        drive(v);
        exec_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exec_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(int'(v.req), "res_o", res_o, v.er);
        chk(int'(v.req), "res_b_o", res_b_o, v.eb);
        chk(int'(v.req), "carry_o", 64'(carry_o), 64'(v.ec));
        // R11 latency from accepting edge to done
        chk(11, "latency", 64'(lat), 64'(v.lat));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        int lat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk(14, "res_o reset", res_o, 64'h0);
        chk(14, "res_b_o reset", res_b_o, 64'h0);
        chk(14, "flags reset", {61'b0, carry_o, busy_o, done_o}, 64'h0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R12 empty window: outputs keep last test's values, done next clock
        v = '{OP_ADD, 1'b0, 4'd6, 4'd2, 4'd0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1357_9BDF_1357_9BDF,
              64'h0000_0000_0000_4444, 64'h0000_0000_0000_4444, 1'b1, 5'd0, 4'd12};
        run_vec(v);

        // R13 strobe held through busy cycles, including the final digit
        @(negedge clk);
        op_i = OP_ADD; dec_mode_i = 1'b0; lo_i = 4'd0; hi_i = 4'd3; imm_i = '0;
        a_i = 64'h0000_0000_0000_0001; b_i = 64'h0000_0000_0000_0002;
        exec_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_i = OP_CLR; lo_i = 4'd0; hi_i = 4'd15;
        a_i = 64'hFFFF_FFFF_FFFF_FFFF; b_i = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        chk(13, "busy before final digit", 64'({busy_o, done_o}), 64'b10);
        @(negedge clk);
        exec_i = 1'b0;
        chk(13, "done after 4 digits", 64'(done_o), 64'h1);
        chk(13, "res ignores busy strobes", res_o, 64'h0000_0000_0000_0003);
        chk(13, "carry ignores busy strobes", 64'(carry_o), 64'h0);
        @(negedge clk);
        chk(13, "no second start", 64'({busy_o, done_o}), 64'h0);

        // R13 strobe in the done cycle starts the next operation
        @(negedge clk);
        op_i = OP_INC; lo_i = 4'd0; hi_i = 4'd0; a_i = 64'h0000_0000_0000_0005;
        b_i = 64'h0;
        exec_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exec_i = 1'b0;
        @(negedge clk);
        chk(13, "first done", 64'(done_o), 64'h1);
        chk(13, "first result", res_o, 64'h0000_0000_0000_0006);
        op_i = OP_CPY; lo_i = 4'd0; hi_i = 4'd1;
        a_i = 64'h1111_0000_0000_0000; b_i = 64'h0000_0000_0000_00AB;
        exec_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exec_i = 1'b0;
        chk(13, "second accepted", 64'(busy_o), 64'h1);
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(13, "second result", res_o, 64'h1111_0000_0000_00AB);
        chk(11, "second latency", 64'(lat), 64'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule